// File: doc/BRIEF.md
# Qualified Reset Pulse Stretcher

This block turns a noisy, asynchronous, active-low reset pin into one clean internal reset that fans out to three subsystems. A synchronizer brings the pin into the clock domain. The pin then has to stay low for a minimum run of consecutive clock samples before the block treats it as a real reset request. Anything shorter is thrown away.

Once a request is accepted, the internal reset is driven active for a fixed stretch of cycles. Pin activity during the stretch is ignored, so bouncing cannot shorten it or extend it. If the pin is still low when the stretch ends, the reset stays active until the pin rises, and a full new stretch follows. Release is always synchronous. All three domain outputs change together, each from its own register, right after a rising clock edge.

A separate power-on reset input puts the block into a stretch of its own. With this input, the subsystems come up reset even if the pin is never pulsed.

Top module: `rst_stretch`

## Requirements
- R1: While `arst_n` is low, every bit of `dom_rst_n` is 0. After `arst_n` rises, the outputs remain 0 for exactly HOLD_CYCLES (255) rising edges and then go to 1, provided the pin stays high.
- R2: Suppose `pin_rst_n` is sampled low on QUAL_CYCLES (5) consecutive rising edges, the first at edge k, while the outputs are 1. Then `dom_rst_n` goes to 0 right after edge k+6. The extra delay comes from the two-stage synchronizer. The outputs never fall before that edge.
- R3: A low pulse sampled on fewer than 5 consecutive edges leaves the outputs at 1. A single high sample clears the run count, so two 4-sample low pulses separated by one high sample also leave the outputs at 1.
- R4: Once asserted by the pin, the outputs stay 0 for exactly 255 cycles, provided the pin is high at the end. Toggling the pin during the stretch does not change its length.
- R5: If the synchronized pin is still low when the stretch ends, the outputs stay 0 until the pin rises. A fresh 255-cycle stretch then starts from the edge at which the high pin reaches the logic, two edges after it is first sampled.
- R6: Outputs change only right after a rising clock edge and are stable for the rest of the cycle. After a release, a new qualified low pulse asserts reset again.
- R7: The three bits of `dom_rst_n` are always equal. Bit 0 goes to the neuron array, bit 1 to the recognition stage and bit 2 to the serial slave controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Power-on reset for the block itself, asynchronous, active low |
| pin_rst_n | input | 1 | External reset pin, asynchronous, active low |
| dom_rst_n | output | DOMAINS (3) | Stretched reset per subsystem, active low: [0] neuron array, [1] recognition stage, [2] serial slave controller |

## Verification
A wrong run counter shows up at the ports as a reset that falls one or more cycles early or late relative to the pin. It can also show up as a short pulse being accepted. Either way it is visible within seven edges of the pin falling. A wrong stretch counter or exit decision changes the width of the low window, or makes the reset release while the pin is still low. That is seen at the rising edge of the outputs, about 255 cycles after entry. Because the bench compares all three outputs with a behavioural model on every cycle, a divergence is reported in the very cycle it appears.

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int QUAL_CYCLES = 5,
  parameter int HOLD_CYCLES = 255,
  parameter int SYNC_STAGES = 2,
  parameter int DOMAINS     = 3
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               pin_rst_n,
  output logic [DOMAINS-1:0] dom_rst_n
);

  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_HOLD = 2'd1, S_WAIT = 2'd2} st_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [QW-1:0]          qual_q, qual_d;
  logic [HW-1:0]          hold_q, hold_d;
  st_t                    st_q, st_d;
  logic                   pin_low;
  logic                   active_d;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_rst_n};

  assign pin_low = ~sync_q[SYNC_STAGES-1];

  always_comb begin
    st_d   = st_q;
    qual_d = qual_q;
    hold_d = hold_q;
    case (st_q)
      S_RUN:
        if (pin_low) begin
          if (qual_q == QW'(QUAL_CYCLES - 1)) begin
            st_d   = S_HOLD;
            qual_d = '0;
            hold_d = '0;
          end else begin
            qual_d = qual_q + 1'b1;
          end
        end else begin
          qual_d = '0;
        end
      S_HOLD:
        if (hold_q == HW'(HOLD_CYCLES - 1)) begin
          st_d   = pin_low ? S_WAIT : S_RUN;
          hold_d = '0;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      S_WAIT:
        if (!pin_low) begin
          st_d   = S_HOLD;
          hold_d = '0;
        end
      default: begin
        st_d   = S_HOLD;
        hold_d = '0;
        qual_d = '0;
      end
    endcase
  end

  assign active_d = (st_d != S_RUN);

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      st_q   <= S_HOLD;
      qual_q <= '0;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      qual_q <= qual_d;
      hold_q <= hold_d;
    end

  for (genvar g = 0; g < DOMAINS; g++) begin : g_dom
    logic out_q;
    always_ff @(posedge clk or negedge arst_n)
      if (!arst_n) out_q <= 1'b0;
      else         out_q <= ~active_d;
    assign dom_rst_n[g] = out_q;
  end

endmodule

// File: rtl/rst_stretch_chk.sv
module rst_stretch_chk #(
  parameter int QUAL_CYCLES = 5,
  parameter int HOLD_CYCLES = 255,
  parameter int SYNC_STAGES = 2,
  parameter int DOMAINS     = 3
) (
  input logic               clk,
  input logic               arst_n,
  input logic               pin_rst_n,
  input logic [DOMAINS-1:0] dom_rst_n
);

  localparam int RW = $clog2(QUAL_CYCLES + 1) + 1;
  localparam int LW = $clog2(HOLD_CYCLES + 1) + 1;

  logic [RW-1:0] low_run;
  logic [LW-1:0] low_len;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      low_run <= '0;
      low_len <= '0;
    end else begin
      if (!pin_rst_n) low_run <= (low_run == RW'(QUAL_CYCLES)) ? low_run : low_run + 1'b1;
      else            low_run <= '0;
      if (!dom_rst_n[0]) low_len <= (low_len == LW'(HOLD_CYCLES)) ? low_len : low_len + 1'b1;
      else               low_len <= '0;
    end

  a_r7_domains_agree: assert property (@(posedge clk) disable iff (!arst_n)
    (dom_rst_n == '0) || (dom_rst_n == '1));

  a_r2_qualified_fall: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(dom_rst_n[0]) |-> ($past(low_run, SYNC_STAGES) >= RW'(QUAL_CYCLES)));

  a_r4_full_stretch: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(dom_rst_n[0]) |-> (low_len >= LW'(HOLD_CYCLES)));

  a_r5_release_pin_high: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(dom_rst_n[0]) |-> $past(pin_rst_n, SYNC_STAGES + 1));

endmodule

bind rst_stretch rst_stretch_chk #(
  .QUAL_CYCLES(QUAL_CYCLES),
  .HOLD_CYCLES(HOLD_CYCLES),
  .SYNC_STAGES(SYNC_STAGES),
  .DOMAINS(DOMAINS)
) u_chk (
  .clk(clk),
  .arst_n(arst_n),
  .pin_rst_n(pin_rst_n),
  .dom_rst_n(dom_rst_n)
);

// File: tb/tb_rst_stretch.sv
module tb_rst_stretch;
  localparam int QUAL = 5;
  localparam int HOLD = 255;
  localparam int DOM  = 3;

  logic           clk = 1'b0;
  logic           arst_n = 1'b0;
  logic           pin_rst_n = 1'b1;
  logic [DOM-1:0] dom_rst_n;

  always #5 clk = ~clk;

  rst_stretch dut (.clk(clk), .arst_n(arst_n), .pin_rst_n(pin_rst_n), .dom_rst_n(dom_rst_n));

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  int    run_len = 0;
  int    last_len = 0;
  bit    done = 0;
  string tag = "R1";

  task automatic check(input bit ok, input string req, input logic [DOM-1:0] act, input logic [DOM-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference: pin history queue, integer run and countdown
  bit hist[$];
  bit seen;
  int low_run, remain;
  bit waiting, m_active;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hist.delete();
      low_run  = 0;
      remain   = HOLD;
      waiting  = 0;
      m_active = 1;
    end else begin
      hist.push_back(pin_rst_n);
      if (hist.size() > 3) void'(hist.pop_front());
      seen = (hist.size() == 3) ? hist[0] : 1'b1;
      if (m_active) begin
        if (waiting) begin
          if (seen) begin
            waiting = 0;
            remain  = HOLD;
          end
        end else begin
          remain--;
          if (remain == 0) begin
            if (!seen) waiting = 1;
            else       m_active = 0;
          end
        end
      end else if (!seen) begin
        low_run++;
        if (low_run == QUAL) begin
          m_active = 1;
          remain   = HOLD;
          low_run  = 0;
        end
      end else begin
        low_run = 0;
      end
    end
  end

  logic [DOM-1:0] early;
  always @(posedge clk) begin
    #2 early = dom_rst_n;
  end

  // every-cycle comparison against the model (R7: all bits equal to the expected level)
  always @(negedge clk) begin
    if (!done) begin
      check(dom_rst_n === {DOM{~m_active}}, {tag, "/R7 model"}, dom_rst_n, {DOM{~m_active}});
      if (cyc > 0) check(early === dom_rst_n, "R6 mid-cycle stable", dom_rst_n, early);
      if (dom_rst_n[0] === 1'b0) run_len++;
      else begin
        if (run_len != 0) last_len = run_len;
        run_len = 0;
      end
      cyc++;
    end
  end

  initial begin
    tag = "R1";
    wait_neg(4);
    check(dom_rst_n === '0, "R1 during power-on reset", dom_rst_n, '0);
    arst_n = 1'b1;
    wait_neg(254);
    check(dom_rst_n === '0, "R1 last stretch cycle", dom_rst_n, '0);
    wait_neg(1);
    check(dom_rst_n === '1, "R1 release after 255", dom_rst_n, '1);

    tag = "R3";
    wait_neg(3);
    pin_rst_n = 1'b0; wait_neg(4); pin_rst_n = 1'b1;
    wait_neg(12);
    check(dom_rst_n === '1, "R3 four-sample pulse ignored", dom_rst_n, '1);
    pin_rst_n = 1'b0; wait_neg(4); pin_rst_n = 1'b1;
    wait_neg(1);
    pin_rst_n = 1'b0; wait_neg(4); pin_rst_n = 1'b1;
    wait_neg(12);
    check(dom_rst_n === '1, "R3 run count cleared by one high", dom_rst_n, '1);

    tag = "R2";
    pin_rst_n = 1'b0; wait_neg(5); pin_rst_n = 1'b1;
    wait_neg(1);
    check(dom_rst_n === '1, "R2 not before edge k+6", dom_rst_n, '1);
    wait_neg(1);
    check(dom_rst_n === '0, "R2 asserted after edge k+6", dom_rst_n, '0);

    tag = "R4";
    for (int i = 0; i < 40; i++) begin
      pin_rst_n = (i % 3 != 0);
      wait_neg(3);
    end
    pin_rst_n = 1'b1;
    wait_neg(200);
    check(dom_rst_n === '1, "R4 released after bouncing", dom_rst_n, '1);
    check(last_len == HOLD, "R4 stretch length", DOM'(last_len), DOM'(HOLD));
    if (last_len != HOLD) $display("FAIL R4 length actual=%0d expected=%0d", last_len, HOLD);

    tag = "R6";
    wait_neg(5);
    pin_rst_n = 1'b0; wait_neg(6); pin_rst_n = 1'b1;
    wait_neg(1);
    check(dom_rst_n === '0, "R6 re-armed after release", dom_rst_n, '0);
    wait_neg(260);
    check(dom_rst_n === '1, "R6 second release", dom_rst_n, '1);

    tag = "R5";
    pin_rst_n = 1'b0;
    wait_neg(300);
    check(dom_rst_n === '0, "R5 held while pin low", dom_rst_n, '0);
    pin_rst_n = 1'b1;
    wait_neg(257);
    check(dom_rst_n === '0, "R5 fresh stretch still active", dom_rst_n, '0);
    wait_neg(1);
    check(dom_rst_n === '1, "R5 fresh stretch ends", dom_rst_n, '1);

    tag = "R7";
    check(dom_rst_n[0] === dom_rst_n[1] && dom_rst_n[1] === dom_rst_n[2], "R7 domains equal", dom_rst_n, {DOM{dom_rst_n[0]}});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule